// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the horizontal and vertical sweep of a display raster from five software-loaded registers. A pixel-clock phase counter groups the pixel clock into characters of `PIX_PER_CHAR` clocks. A character counter steps once per character. A line counter steps each time the character counter wraps. From these counts and the programmed fields the block decodes a horizontal sync pulse, a vertical sync pulse and a display-enable window. Each sync pulse has its own selectable polarity.

All horizontal quantities are expressed in characters and all vertical quantities in lines. Software loads the four timing registers while the raster is stopped, then sets both enable bits in the control register to start it. While either enable bit is clear, both counters are held at zero and both sync outputs sit at their idle level. While either enable bit is set, writes to the timing registers are dropped.

Top module: `crtc_timing`

## Requirements
- R1: After reset, charCount and lineCount are 0, hSync and vSync are 0, and dispEn is 0.
- R2: Address 0 holds the last character index of a line in bits [8:0] and the last displayed character index in bits [24:16]. When running, one line lasts (bits[8:0] + 1) × PIX_PER_CHAR clocks.
- R3: When running, charCount advances once every PIX_PER_CHAR clocks and returns to 0 after its programmed last index. lineCount advances when charCount wraps and returns to 0 after the last line index. That last line index is held in address 2 bits [10:0], and the last displayed line index is in address 2 bits [26:16].
- R4: In address 1, the horizontal sync start is a 9-bit character index: bits [7:0] hold its low byte and bit 12 holds its bit 8. Bits [21:16] hold the width in characters. The pulse is active for characters start through start + width − 1, which is width × PIX_PER_CHAR clocks.
- R5: In address 3, bits [10:0] hold the vertical sync start line and bits [20:16] hold the width in lines. The pulse is active for lines start through start + width − 1.
- R6: Bit 31 of address 1 selects active-low hSync, and bit 31 of address 3 selects active-low vSync. When the bit is clear, the sync is active high. The idle level is the inverse of the active level, including while stopped.
- R7: dispEn is 1 only while running, with charCount ≤ the horizontal display field and lineCount ≤ the vertical display field.
- R8: Address 4 bit 0 is the output enable and bit 1 is the count enable. The raster runs only when both are 1. Otherwise both counters are forced to 0 on the next clock, the syncs are idle and dispEn is 0.
- R9: A write to addresses 0 to 3 is ignored while either control bit is set.
- R10: A sync width of 0 produces no sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| hSync | output | 1 | Horizontal sync, programmed polarity |
| vSync | output | 1 | Vertical sync, programmed polarity |
| dispEn | output | 1 | Active display window |
| charCount | output | 9 | Current character within the line |
| lineCount | output | 11 | Current line within the frame |

## Verification
A standard 640x480 mode with both syncs active low is loaded first. This mode shows the line period, the horizontal pulse width, the display window and the idle level when negative polarity is selected. A second, short-frame mode with positive polarity and a horizontal sync start above 255 exercises the split high bit at position 12. It also checks the vertical pulse period and width against the field values. A third pattern loads a zero-width pulse to tell "no pulse" apart from a pulse one character long. Further tests do the following:
- Write the timing registers while the raster runs, to show that those writes are dropped.
- Clear one enable bit at a time, to show that each bit alone halts the counters.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int H_W   = 9;
  localparam int V_W   = 11;
  localparam int HSW_W = 6;
  localparam int VSW_W = 5;

  localparam logic [2:0] A_HTIME = 3'd0;
  localparam logic [2:0] A_HSYNC = 3'd1;
  localparam logic [2:0] A_VTIME = 3'd2;
  localparam logic [2:0] A_VSYNC = 3'd3;
  localparam logic [2:0] A_CTRL  = 3'd4;

  typedef struct packed {
    logic [H_W-1:0]   hTotal;
    logic [H_W-1:0]   hDisp;
    logic [H_W-1:0]   hSyncStart;
    logic [HSW_W-1:0] hSyncWidth;
    logic             hSyncNeg;
    logic [V_W-1:0]   vTotal;
    logic [V_W-1:0]   vDisp;
    logic [V_W-1:0]   vSyncStart;
    logic [VSW_W-1:0] vSyncWidth;
    logic             vSyncNeg;
  } crtc_cfg_t;

  typedef struct packed {
    logic hold;
    logic charStep;
  } crtc_step_t;
endpackage

// File: rtl/crtc_ctrl.sv
module crtc_ctrl
  import crtc_pkg::*;
#(
  parameter int PIX_PER_CHAR = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output crtc_cfg_t   cfg,
  output crtc_step_t  step
);
  localparam int PW = (PIX_PER_CHAR > 1) ? $clog2(PIX_PER_CHAR) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PIX_PER_CHAR - 1);

  logic [1:0]    ctrlBits;
  logic [PW-1:0] phase;
  logic          running;
  logic          timingOpen;
  logic          unusedWrBits;

  assign running      = &ctrlBits;
  assign timingOpen   = (ctrlBits == 2'b00);
  assign unusedWrBits = ^regWrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg      <= '0;
      ctrlBits <= 2'b00;
    end else if (regWrEn) begin
      if (regAddr == A_CTRL) begin
        ctrlBits <= regWrData[1:0];
      end else if (timingOpen) begin
        case (regAddr)
          A_HTIME: begin
            cfg.hTotal <= regWrData[H_W-1:0];
            cfg.hDisp  <= regWrData[16 +: H_W];
          end
          A_HSYNC: begin
            cfg.hSyncStart <= {regWrData[12], regWrData[7:0]};
            cfg.hSyncWidth <= regWrData[16 +: HSW_W];
            cfg.hSyncNeg   <= regWrData[31];
          end
          A_VTIME: begin
            cfg.vTotal <= regWrData[V_W-1:0];
            cfg.vDisp  <= regWrData[16 +: V_W];
          end
          A_VSYNC: begin
            cfg.vSyncStart <= regWrData[V_W-1:0];
            cfg.vSyncWidth <= regWrData[16 +: VSW_W];
            cfg.vSyncNeg   <= regWrData[31];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !running)     phase <= '0;
    else if (phase == PH_LAST) phase <= '0;
    else                       phase <= phase + 1'b1;
  end

  assign step.hold     = !running;
  assign step.charStep = running && (phase == PH_LAST);

  // R9: timing registers frozen while either enable bit is set
  p_locked_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr != A_CTRL && ctrlBits != 2'b00) |=> $stable(cfg));
endmodule

// File: rtl/crtc_dp.sv
module crtc_dp
  import crtc_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  crtc_cfg_t      cfg,
  input  crtc_step_t     step,
  output logic [H_W-1:0] charCount,
  output logic [V_W-1:0] lineCount,
  output logic           hSync,
  output logic           vSync,
  output logic           dispEn
);
  logic [H_W:0] hEnd;
  logic [V_W:0] vEnd;
  logic         hActive;
  logic         vActive;
  logic         lineWrap;

  assign lineWrap = (charCount == cfg.hTotal);

  always_ff @(posedge clk) begin
    if (!rstN || step.hold) begin
      charCount <= '0;
      lineCount <= '0;
    end else if (step.charStep) begin
      if (lineWrap) begin
        charCount <= '0;
        if (lineCount == cfg.vTotal) lineCount <= '0;
        else                         lineCount <= lineCount + 1'b1;
      end else begin
        charCount <= charCount + 1'b1;
      end
    end
  end

  assign hEnd = {1'b0, cfg.hSyncStart} + {{(H_W+1-HSW_W){1'b0}}, cfg.hSyncWidth};
  assign vEnd = {1'b0, cfg.vSyncStart} + {{(V_W+1-VSW_W){1'b0}}, cfg.vSyncWidth};

  assign hActive = !step.hold && (charCount >= cfg.hSyncStart)
                   && ({1'b0, charCount} < hEnd);
  assign vActive = !step.hold && (lineCount >= cfg.vSyncStart)
                   && ({1'b0, lineCount} < vEnd);

  assign hSync  = hActive ^ cfg.hSyncNeg;
  assign vSync  = vActive ^ cfg.vSyncNeg;
  assign dispEn = !step.hold && (charCount <= cfg.hDisp) && (lineCount <= cfg.vDisp);

  // R3: character count never passes its programmed last index
  p_char_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    !step.hold |-> charCount <= cfg.hTotal);
  // R3: frame wrap returns line count to zero
  p_line_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (step.charStep && lineWrap && lineCount == cfg.vTotal) |=> lineCount == '0);
  // R3: line count steps by one on a character wrap inside the frame
  p_line_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (step.charStep && lineWrap && lineCount != cfg.vTotal)
      |=> lineCount == $past(lineCount) + 1'b1);
  // R8: halted raster clears both counters
  p_halt_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    step.hold |=> (charCount == '0 && lineCount == '0));
  // R7: no display window while halted
  p_dispen_halt_r7: assert property (@(posedge clk) disable iff (!rstN)
    step.hold |-> !dispEn);
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
  import crtc_pkg::*;
#(
  parameter int PIX_PER_CHAR = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic        hSync,
  output logic        vSync,
  output logic        dispEn,
  output logic [8:0]  charCount,
  output logic [10:0] lineCount
);
  crtc_cfg_t  cfg;
  crtc_step_t step;

  crtc_ctrl #(.PIX_PER_CHAR(PIX_PER_CHAR)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .cfg(cfg), .step(step)
  );

  crtc_dp u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .step(step),
    .charCount(charCount), .lineCount(lineCount),
    .hSync(hSync), .vSync(vSync), .dispEn(dispEn)
  );
endmodule

// File: tb/crtc_timing_test.sv
module crtc_timing_test;
  localparam int PPC = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        hSync, vSync, dispEn;
  logic [8:0]  charCount;
  logic [10:0] lineCount;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  crtc_timing #(.PIX_PER_CHAR(PPC)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .hSync(hSync), .vSync(vSync), .dispEn(dispEn),
    .charCount(charCount), .lineCount(lineCount)
  );

  // behavioural reference state
  int mCtrl = 0, mPix = 0, mChar = 0, mLine = 0;
  int mHTot = 0, mHDisp = 0, mHs = 0, mHw = 0, mVTot = 0, mVDisp = 0, mVs = 0, mVw = 0;
  bit mHNeg = 0, mVNeg = 0;
  bit cmpOn = 1;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mPix = 0; mChar = 0; mLine = 0;
      mHTot = 0; mHDisp = 0; mHs = 0; mHw = 0; mHNeg = 0;
      mVTot = 0; mVDisp = 0; mVs = 0; mVw = 0; mVNeg = 0;
    end else begin
      if ((mCtrl & 3) != 3) begin
        mPix = 0; mChar = 0; mLine = 0;
      end else if (mPix == PPC - 1) begin
        mPix = 0;
        if (mChar == mHTot) begin
          mChar = 0;
          mLine = (mLine == mVTot) ? 0 : mLine + 1;
        end else mChar = mChar + 1;
      end else mPix = mPix + 1;
      if (regWrEn) begin
        if (regAddr == 3'd4) mCtrl = int'(regWrData[1:0]);
        else if ((mCtrl & 3) == 0) begin
          case (regAddr)
            3'd0: begin mHTot = int'(regWrData[8:0]); mHDisp = int'(regWrData[24:16]); end
            3'd1: begin mHs = int'({regWrData[12], regWrData[7:0]}); mHw = int'(regWrData[21:16]); mHNeg = regWrData[31]; end
            3'd2: begin mVTot = int'(regWrData[10:0]); mVDisp = int'(regWrData[26:16]); end
            3'd3: begin mVs = int'(regWrData[10:0]); mVw = int'(regWrData[20:16]); mVNeg = regWrData[31]; end
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      bit run;
      bit hA, vA, de;
      run = ((mCtrl & 3) == 3);
      hA = run && mChar >= mHs && mChar < mHs + mHw;
      vA = run && mLine >= mVs && mLine < mVs + mVw;
      de = run && mChar <= mHDisp && mLine <= mVDisp;
      chk("R3 charCount", int'(charCount), mChar);
      chk("R3 lineCount", int'(lineCount), mLine);
      chk("R4/R6 hSync", int'(hSync), int'(hA ^ mHNeg));
      chk("R5/R6 vSync", int'(vSync), int'(vA ^ mVNeg));
      chk("R7 dispEn", int'(dispEn), int'(de));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // measure pulse width and period, in clocks, of one sync output
  task automatic meas(input bit isV, input bit neg, output int period, output int width);
    int rest;
    width = 0; rest = 0;
    while (((isV ? vSync : hSync) ^ neg) == 1'b1) @(negedge clk);
    while (((isV ? vSync : hSync) ^ neg) == 1'b0) @(negedge clk);
    while (((isV ? vSync : hSync) ^ neg) == 1'b1) begin width++; @(negedge clk); end
    while (((isV ? vSync : hSync) ^ neg) == 1'b0) begin rest++; @(negedge clk); end
    period = width + rest;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int per, wid, cnt;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 charCount", int'(charCount), 0);
    chk("R1 lineCount", int'(lineCount), 0);
    chk("R1 hSync", int'(hSync), 0);
    chk("R1 vSync", int'(vSync), 0);
    chk("R1 dispEn", int'(dispEn), 0);
    rstN = 1'b1;

    // 640x480, both syncs active low
    wr(3'd0, (32'd79 << 16) | 32'd99);
    wr(3'd1, (32'd1 << 31) | (32'd12 << 16) | 32'd81);
    wr(3'd2, (32'd479 << 16) | 32'd524);
    wr(3'd3, (32'd1 << 31) | (32'd2 << 16) | 32'd489);
    @(negedge clk);
    chk("R6 idle hSync low-active", int'(hSync), 1);
    chk("R6 idle vSync low-active", int'(vSync), 1);
    wr(3'd4, 32'd3);
    meas(1'b0, 1'b1, per, wid);
    chk("R2 line period", per, 100 * PPC);
    chk("R4 hsync width", wid, 12 * PPC);

    // R9: write while running is dropped
    wr(3'd0, (32'd10 << 16) | 32'd20);
    meas(1'b0, 1'b1, per, wid);
    chk("R9 period after dropped write", per, 100 * PPC);

    // R8: each enable bit alone halts
    wr(3'd4, 32'd1);
    repeat (3) @(negedge clk);
    chk("R8 char held (bit0 only)", int'(charCount), 0);
    chk("R8 dispEn off (bit0 only)", int'(dispEn), 0);
    wr(3'd4, 32'd2);
    repeat (20) @(negedge clk);
    chk("R8 char held (bit1 only)", int'(charCount), 0);
    chk("R8 line held (bit1 only)", int'(lineCount), 0);
    chk("R8 hSync idle", int'(hSync), 1);

    // short frame, positive polarity, sync start 260 uses bit 12
    wr(3'd4, 32'd0);
    wr(3'd0, (32'd200 << 16) | 32'd299);
    wr(3'd1, (32'd5 << 16) | (32'd1 << 12) | 32'd4);
    wr(3'd2, (32'd2 << 16) | 32'd3);
    wr(3'd3, (32'd2 << 16) | 32'd1);
    wr(3'd4, 32'd3);
    meas(1'b0, 1'b0, per, wid);
    chk("R4 hsync width high start", wid, 5 * PPC);
    chk("R2 line period 300", per, 300 * PPC);
    meas(1'b1, 1'b0, per, wid);
    chk("R5 vsync period", per, 4 * 300 * PPC);
    chk("R5 vsync width", wid, 2 * 300 * PPC);

    // R10 zero width
    wr(3'd4, 32'd0);
    wr(3'd1, 32'd2);
    wr(3'd4, 32'd3);
    cnt = 0;
    for (int i = 0; i < 2 * 300 * PPC; i++) begin
      @(negedge clk);
      if (hSync) cnt++;
    end
    chk("R10 zero-width pulses", cnt, 0);

    finish_run();
  end
endmodule